// File: doc/BRIEF.md
# PCM Serial Frame Transceiver

This block is the bit-level engine of a short-frame PCM audio port. In each frame it sends one 16-bit signed sample out on a serial data line, most significant bit first, and captures one 16-bit sample from the incoming serial line. The port is always the clock and frame master. A separate clock generator supplies two one-cycle strobes per bit period: a leading strobe where data is launched and a trailing strobe where data is captured. This matches an inverted bit clock. The generator also supplies an active-high frame strobe that coincides with the leading strobe of the sync bit period.

Transmit samples come from a show-ahead FIFO through a pop handshake, and received samples go to a FIFO through a push handshake. The FIFO storage sits outside the block. Each direction has its own alignment control. With the control set, the most significant bit occupies the bit period after the sync period. With it clear, that bit shares the sync period. When the transmit FIFO is empty at frame start, the frame carries zeros and a starvation pulse is raised. When the receive FIFO is full at word completion, the word is dropped and an overflow pulse is raised.

Top module: `pcm_frame_xcvr`

## Requirements
- R1: With `tx_msb_late`=0, the transmit word's bit 15 is driven on `sdo` during the sync bit period, and bits 14..0 follow in the next 15 bit periods.
- R2: With `tx_msb_late`=1, `sdo` is 0 during the sync bit period, and bits 15..0 of the word occupy the following 16 bit periods.
- R3: Every bit period after the 16 data bits of a frame drives `sdo`=0. `sdo` changes only in the clock cycle after a `bit_lead` strobe.
- R4: If `tx_empty`=1 at frame start while transmit is active, the whole frame is driven as zeros. `tx_starve` pulses for one cycle, in the cycle after the frame strobe.
- R5: While transmit is active and `tx_empty`=0, `tx_pop` is high for exactly one cycle per frame, in the cycle of the frame strobe, and `tx_data` is taken in that same cycle.
- R6: Receive bits are sampled on `bit_trail`. With `rx_msb_late`=0, the first sample (word bit 15) is taken in the sync bit period; with `rx_msb_late`=1, it is taken in the period after. `sdi` values outside those 16 periods do not affect the word.
- R7: One cycle after the 16th received bit is sampled, `rx_push` pulses with `rx_wdata` holding the word, unless `rx_full` was high in the sampling cycle. In that case there is no push and `rx_ovf` pulses instead.
- R8: Transmit runs only while `glb_en` and `tx_en` are both 1; otherwise `sdo` is 0 and there are no pops or starvation pulses. Receive runs only while `glb_en` and `rx_en` are both 1; otherwise there are no pushes or overflow pulses.
- R9: After reset, `sdo`, `tx_starve`, `rx_push` and `rx_ovf` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global port enable |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| tx_msb_late | input | 1 | 1: transmit MSB one bit period after sync |
| rx_msb_late | input | 1 | 1: receive MSB one bit period after sync |
| bit_lead | input | 1 | One-cycle strobe at the launch edge of each bit period |
| bit_trail | input | 1 | One-cycle strobe at the capture edge of each bit period |
| frame_tick | input | 1 | Frame sync strobe, coincident with `bit_lead` of the sync period |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| tx_pop | output | 1 | Pop request to the transmit FIFO |
| tx_data | input | 16 | Head word of the transmit FIFO |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_starve | output | 1 | Pulse: frame started with no sample available |
| rx_push | output | 1 | Push strobe to the receive FIFO |
| rx_wdata | output | 16 | Received word |
| rx_full | input | 1 | Receive FIFO full |
| rx_ovf | output | 1 | Pulse: received word dropped on a full FIFO |

## Verification
`tx_pop` is combinational, so it is read in the same cycle as the frame strobe, after the inputs settle.

Three results appear one cycle later, when the registers update:
- `sdo` follows one cycle after each `bit_lead`, so the bench reads it at the capture point of that bit period.
- `tx_starve` is due one cycle after the frame strobe.
- `rx_push`, `rx_wdata` and `rx_ovf` are due one cycle after the 16th `bit_trail`.

The bench drives inputs and samples on falling clock edges. It counts every pulse over a full 20-bit frame, so a pulse that arrives early, late or twice is caught. `sdi` is held at 1 outside the data window, so a shifted capture window corrupts the word.

// File: rtl/pcm_xcvr_pkg.sv
package pcm_xcvr_pkg;
  parameter int SAMPLE_W = 16;
  localparam int CNT_W = $clog2(SAMPLE_W + 1);
endpackage

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter #(
  parameter int W = pcm_xcvr_pkg::SAMPLE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         msb_late,
  input  logic         bit_lead,
  input  logic         frame_tick,
  input  logic [W-1:0] tx_data,
  input  logic         tx_empty,
  output logic         tx_pop,
  output logic         tx_starve,
  output logic         sdo
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sreg_q, sreg_n;
  logic [CW-1:0] left_q, left_n;
  logic          sdo_q, sdo_n;
  logic          starve_q, starve_n;
  logic          frame_go;
  logic [W-1:0]  word;

  assign frame_go = active & bit_lead & frame_tick;
  assign tx_pop   = frame_go & ~tx_empty;
  assign word     = tx_empty ? '0 : tx_data;

  always_comb begin
    sreg_n   = sreg_q;
    left_n   = left_q;
    sdo_n    = sdo_q;
    starve_n = 1'b0;
    if (!active) begin
      sreg_n = '0;
      left_n = '0;
      sdo_n  = 1'b0;
    end else if (bit_lead) begin
      if (frame_tick) begin
        starve_n = tx_empty;
        if (msb_late) begin
          sdo_n  = 1'b0;
          sreg_n = word;
          left_n = CW'(W);
        end else begin
          sdo_n  = word[W-1];
          sreg_n = {word[W-2:0], 1'b0};
          left_n = CW'(W - 1);
        end
      end else if (left_q != '0) begin
        sdo_n  = sreg_q[W-1];
        sreg_n = {sreg_q[W-2:0], 1'b0};
        left_n = left_q - 1'b1;
      end else begin
        sdo_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q   <= '0;
      left_q   <= '0;
      sdo_q    <= 1'b0;
      starve_q <= 1'b0;
    end else begin
      sreg_q   <= sreg_n;
      left_q   <= left_n;
      sdo_q    <= sdo_n;
      starve_q <= starve_n;
    end
  end

  assign sdo       = sdo_q;
  assign tx_starve = starve_q;

  AST_SDO_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (sdo == 1'b0)); // R8
  AST_STARVE_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_starve |-> $past(tx_empty)); // R4
  AST_SDO_MOVES_ON_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> ($past(bit_lead) || !$past(active))); // R3
endmodule

// File: rtl/pcm_rx_shifter.sv
module pcm_rx_shifter #(
  parameter int W = pcm_xcvr_pkg::SAMPLE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         msb_late,
  input  logic         bit_lead,
  input  logic         bit_trail,
  input  logic         frame_tick,
  input  logic         sdi,
  input  logic         rx_full,
  output logic         rx_push,
  output logic [W-1:0] rx_wdata,
  output logic         rx_ovf
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sreg_q, sreg_n;
  logic [CW-1:0] left_q, left_n;
  logic          skip_q, skip_n;
  logic          push_q, push_n;
  logic          ovf_q, ovf_n;
  logic [W-1:0]  wdata_q, wdata_n;
  logic [W-1:0]  shifted;

  assign shifted = {sreg_q[W-2:0], sdi};

  always_comb begin
    sreg_n  = sreg_q;
    left_n  = left_q;
    skip_n  = skip_q;
    wdata_n = wdata_q;
    push_n  = 1'b0;
    ovf_n   = 1'b0;
    if (!active) begin
      left_n = '0;
      skip_n = 1'b0;
    end else if (bit_lead && frame_tick) begin
      left_n = CW'(W);
      skip_n = msb_late;
    end else if (bit_trail) begin
      if (skip_q) begin
        skip_n = 1'b0;
      end else if (left_q != '0) begin
        sreg_n = shifted;
        left_n = left_q - 1'b1;
        if (left_q == CW'(1)) begin
          push_n = ~rx_full;
          ovf_n  = rx_full;
          if (!rx_full) wdata_n = shifted;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q  <= '0;
      left_q  <= '0;
      skip_q  <= 1'b0;
      push_q  <= 1'b0;
      ovf_q   <= 1'b0;
      wdata_q <= '0;
    end else begin
      sreg_q  <= sreg_n;
      left_q  <= left_n;
      skip_q  <= skip_n;
      push_q  <= push_n;
      ovf_q   <= ovf_n;
      wdata_q <= wdata_n;
    end
  end

  assign rx_push  = push_q;
  assign rx_ovf   = ovf_q;
  assign rx_wdata = wdata_q;

  AST_PUSH_AFTER_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push || rx_ovf) |-> $past(bit_trail)); // R7
  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !$past(rx_full)); // R7
  AST_RX_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !rx_push); // R8
endmodule

// File: rtl/pcm_frame_xcvr.sv
module pcm_frame_xcvr #(
  parameter int W = pcm_xcvr_pkg::SAMPLE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         glb_en,
  input  logic         tx_en,
  input  logic         rx_en,
  input  logic         tx_msb_late,
  input  logic         rx_msb_late,
  input  logic         bit_lead,
  input  logic         bit_trail,
  input  logic         frame_tick,
  output logic         sdo,
  input  logic         sdi,
  output logic         tx_pop,
  input  logic [W-1:0] tx_data,
  input  logic         tx_empty,
  output logic         tx_starve,
  output logic         rx_push,
  output logic [W-1:0] rx_wdata,
  input  logic         rx_full,
  output logic         rx_ovf
);
  logic tx_act, rx_act;

  assign tx_act = glb_en & tx_en;
  assign rx_act = glb_en & rx_en;

  pcm_tx_shifter #(.W(W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (tx_act),
    .msb_late   (tx_msb_late),
    .bit_lead   (bit_lead),
    .frame_tick (frame_tick),
    .tx_data    (tx_data),
    .tx_empty   (tx_empty),
    .tx_pop     (tx_pop),
    .tx_starve  (tx_starve),
    .sdo        (sdo)
  );

  pcm_rx_shifter #(.W(W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (rx_act),
    .msb_late   (rx_msb_late),
    .bit_lead   (bit_lead),
    .bit_trail  (bit_trail),
    .frame_tick (frame_tick),
    .sdi        (sdi),
    .rx_full    (rx_full),
    .rx_push    (rx_push),
    .rx_wdata   (rx_wdata),
    .rx_ovf     (rx_ovf)
  );
endmodule

// File: tb/pcm_frame_xcvr_tb.sv
module pcm_frame_xcvr_tb;
  localparam int NV = 6;
  localparam int FB = 20;
  // entry: {tx_late, rx_late, tx_empty, rx_full, tx_word, rx_word}
  localparam logic [35:0] VEC [NV] = '{
    {4'b0000, 16'hA5C3, 16'h1234},
    {4'b1100, 16'h8001, 16'hFEDC},
    {4'b0100, 16'h7FFE, 16'h8000},
    {4'b1000, 16'hFFFF, 16'h0001},
    {4'b0010, 16'h5555, 16'hAAAA},
    {4'b1101, 16'h1357, 16'h2468}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic glb_en, tx_en, rx_en, tx_msb_late, rx_msb_late;
  logic bit_lead, bit_trail, frame_tick, sdi, tx_empty, rx_full;
  logic [15:0] tx_data;
  logic sdo, tx_pop, tx_starve, rx_push, rx_ovf;
  logic [15:0] rx_wdata;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [FB-1:0] got_sdo;
  int n_pop, n_starve, n_push, n_ovf;
  logic [15:0] last_word;

  always #5 clk = ~clk;

  pcm_frame_xcvr u_dut (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .tx_en(tx_en), .rx_en(rx_en),
    .tx_msb_late(tx_msb_late), .rx_msb_late(rx_msb_late),
    .bit_lead(bit_lead), .bit_trail(bit_trail), .frame_tick(frame_tick),
    .sdo(sdo), .sdi(sdi), .tx_pop(tx_pop), .tx_data(tx_data),
    .tx_empty(tx_empty), .tx_starve(tx_starve), .rx_push(rx_push),
    .rx_wdata(rx_wdata), .rx_full(rx_full), .rx_ovf(rx_ovf)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic tl, input logic rl, input logic te,
                           input logic rf, input logic [15:0] tw,
                           input logic [15:0] rw);
    got_sdo = '0; n_pop = 0; n_starve = 0; n_push = 0; n_ovf = 0;
    last_word = '0;
    @(negedge clk);
    tx_msb_late = tl; rx_msb_late = rl; tx_empty = te; rx_full = rf;
    tx_data = tw;
    for (int p = 0; p < FB; p++) begin
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        if (tx_starve) n_starve++;
        if (rx_ovf) n_ovf++;
        if (rx_push) begin n_push++; last_word = rx_wdata; end
        if (c == 2) got_sdo[FB-1-p] = sdo;
        bit_lead   = (c == 0);
        bit_trail  = (c == 2);
        frame_tick = (c == 0) && (p == 0);
        if (c == 0) begin
          int idx = rl ? p - 1 : p;
          sdi = (idx >= 0 && idx < 16) ? rw[15-idx] : 1'b1;
        end
        #1;
        if (tx_pop) n_pop++;
      end
    end
    @(negedge clk);
    if (tx_starve) n_starve++;
    if (rx_ovf) n_ovf++;
    if (rx_push) begin n_push++; last_word = rx_wdata; end
    bit_lead = 1'b0; bit_trail = 1'b0; frame_tick = 1'b0;
  endtask

  function automatic logic [FB-1:0] exp_sdo(input logic act, input logic tl,
                                            input logic te, input logic [15:0] tw);
    logic [15:0] w = (te || !act) ? 16'h0 : tw;
    return tl ? {1'b0, w, 3'b000} : {w, 4'b0000};
  endfunction

  initial begin
    glb_en = 0; tx_en = 0; rx_en = 0; tx_msb_late = 0; rx_msb_late = 0;
    bit_lead = 0; bit_trail = 0; frame_tick = 0; sdi = 0; tx_empty = 1;
    rx_full = 0; tx_data = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(sdo == 0 && tx_starve == 0 && rx_push == 0 && rx_ovf == 0, "R9",
        {28'h0, sdo, tx_starve, rx_push, rx_ovf}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    chk(sdo == 0 && rx_push == 0, "R9", {30'h0, sdo, rx_push}, 32'h0);

    glb_en = 1; tx_en = 1; rx_en = 1;
    for (int i = 0; i < NV; i++) begin
      logic tl = VEC[i][35], rl = VEC[i][34], te = VEC[i][33], rf = VEC[i][32];
      logic [15:0] tw = VEC[i][31:16], rw = VEC[i][15:0];
      logic [FB-1:0] es = exp_sdo(1'b1, tl, te, tw);
      run_frame(tl, rl, te, rf, tw, rw);
      chk(got_sdo == es, tl ? "R2" : "R1", 32'(got_sdo), 32'(es));
      chk((got_sdo & (tl ? 20'h00007 : 20'h0000F)) == 0, "R3",
          32'(got_sdo), 32'(es));
      chk(n_pop == (te ? 0 : 1), "R5", n_pop, te ? 0 : 1);
      chk(n_starve == (te ? 1 : 0), "R4", n_starve, te ? 1 : 0);
      chk(n_push == (rf ? 0 : 1), "R7", n_push, rf ? 0 : 1);
      chk(n_ovf == (rf ? 1 : 0), "R7", n_ovf, rf ? 1 : 0);
      if (!rf) chk(last_word == rw, "R6", last_word, rw);
    end

    // R8: transmit off, receive still running
    tx_en = 0;
    run_frame(1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFF, 16'h0F0F);
    chk(got_sdo == 0, "R8", 32'(got_sdo), 0);
    chk(n_pop == 0 && n_starve == 0, "R8", n_pop + n_starve, 0);
    chk(n_push == 1 && last_word == 16'h0F0F, "R8", last_word, 16'h0F0F);

    // R8: receive off, transmit running
    tx_en = 1; rx_en = 0;
    run_frame(1'b0, 1'b0, 1'b0, 1'b0, 16'hC001, 16'h3333);
    chk(got_sdo == exp_sdo(1'b1, 1'b0, 1'b0, 16'hC001), "R8",
        32'(got_sdo), 32'(exp_sdo(1'b1, 1'b0, 1'b0, 16'hC001)));
    chk(n_push == 0 && n_ovf == 0, "R8", n_push + n_ovf, 0);

    // R8: global enable off stops both directions
    rx_en = 1; glb_en = 0;
    run_frame(1'b0, 1'b0, 1'b1, 1'b1, 16'hFFFF, 16'hFFFF);
    chk(got_sdo == 0 && n_pop == 0 && n_starve == 0, "R8",
        32'(got_sdo), 0);
    chk(n_push == 0 && n_ovf == 0, "R8", n_push + n_ovf, 0);

    // R4 again with late alignment: starved frame is all zero
    glb_en = 1;
    run_frame(1'b1, 1'b0, 1'b1, 1'b0, 16'hFFFF, 16'h4321);
    chk(got_sdo == 0 && n_starve == 1 && n_pop == 0, "R4",
        32'(got_sdo), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule